// File: doc/BRIEF.md
# Opmask OR-Test Flag Unit

This unit executes the mask OR-and-test operation against a file of eight 64-bit opmask registers. A decoded instruction arrives as an opcode byte, the VEX W bit, the VEX L bit, the two-bit implied-prefix field, the ModRM byte and a valid strobe. The unit reads the two masks that the ModRM fields name and ORs them. The encoding selects an operand width of 8, 16, 32 or 64 bits, and the OR is limited to that width. The unit then loads zero and carry into its status flags and clears the other four arithmetic flags.

An illegal encoding leaves the flags alone and raises a one-cycle invalid-opcode pulse. The mask registers are loaded through a separate one-register-per-cycle write port. If that port writes in the same cycle as a test, the write lands after the test has read the registers.

Top module: `mask_or_test_unit`

## Requirements
- R1: The width comes from W and the prefix field (prefix 00 = none, 01 = 66h). W=0 with no prefix gives 16 bits, W=0 with 66h gives 8, W=1 with no prefix gives 64, and W=1 with 66h gives 32.
- R2: ZF becomes 1 when the width-limited OR of the two masks is all zeros, and 0 otherwise.
- R3: CF becomes 1 when the width-limited OR is all ones at the selected width, and 0 otherwise.
- R4: Mask bits above the selected width have no effect on ZF or CF.
- R5: OF, SF, AF and PF are 0 after every legal execution.
- R6: The flags change only on the rising edge that samples a valid, legal instruction. They are visible right after that edge and stay unchanged while no instruction is issued.
- R7: An encoding is invalid when any of these holds: the opcode is not 98h, L is 1, the prefix field is 10 or 11, or ModRM[7:6] is not 11b. On an invalid encoding the flags keep their value, and the invalid output is 1 for exactly the cycle after that edge.
- R8: ModRM[5:3] selects the first mask and ModRM[2:0] selects the second. The test never changes either mask.
- R9: The write port loads the whole 64-bit register it names on the next rising edge. A test issued in the same cycle reads the value held before that write.
- R10: Reset clears all masks, all flags and the invalid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | Instruction valid strobe |
| opc_byte | input | 8 | Opcode byte |
| vex_w | input | 1 | VEX W bit |
| vex_l | input | 1 | VEX L bit |
| vex_pp | input | 2 | Implied-prefix field |
| modrm | input | 8 | ModRM byte |
| mwr_en | input | 1 | Mask write enable |
| mwr_idx | input | 3 | Mask register written |
| mwr_data | input | 64 | Mask write data |
| zf_o | output | 1 | Zero flag |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag |
| sf_o | output | 1 | Sign flag |
| af_o | output | 1 | Auxiliary-carry flag |
| pf_o | output | 1 | Parity flag |
| ill_o | output | 1 | Invalid-encoding pulse |

## Verification
The masks have no read port, so a corrupt mask register can only be seen through a later test that selects it. That test shows wrong ZF or CF one cycle after it issues. The bench therefore tests each register again after writes and after earlier tests, and uses several widths so that bits outside a lane are covered. A wrong width decode or a bad upper-bit mask shows up as a single wrong flag right after the issuing edge. A decode that lets an illegal form through changes the flags in the cycle where the invalid pulse should appear instead.

// File: rtl/mot_pkg.sv
package mot_pkg;
    localparam int MASK_W = 64;
    localparam int NUM_MASKS = 8;
    localparam int IDX_W = $clog2(NUM_MASKS);
    localparam logic [7:0] OPC_ORTEST = 8'h98;

    typedef enum logic [1:0] {
        WID_8  = 2'd0,
        WID_16 = 2'd1,
        WID_32 = 2'd2,
        WID_64 = 2'd3
    } wid_e;

    typedef struct packed {
        logic zf;
        logic cf;
        logic of;
        logic sf;
        logic af;
        logic pf;
    } flags_t;
endpackage

// File: rtl/mot_decode.sv
module mot_decode
    import mot_pkg::*;
(
    input  logic [7:0]       opc_byte,
    input  logic             vex_w,
    input  logic             vex_l,
    input  logic [1:0]       vex_pp,
    input  logic [7:0]       modrm,
    output logic             legal,
    output wid_e             wid,
    output logic [IDX_W-1:0] idx_a,
    output logic [IDX_W-1:0] idx_b
);
    logic pp_ok;

    always_comb begin
        pp_ok = (vex_pp == 2'b00) || (vex_pp == 2'b01);
        legal = (opc_byte == OPC_ORTEST) && !vex_l && pp_ok && (modrm[7:6] == 2'b11);
        unique case ({vex_w, vex_pp[0]})
            2'b00:   wid = WID_16;
            2'b01:   wid = WID_8;
            2'b10:   wid = WID_64;
            default: wid = WID_32;
        endcase
        idx_a = modrm[3 +: IDX_W];
        idx_b = modrm[0 +: IDX_W];
    end
endmodule

// File: rtl/mot_mask_file.sv
module mot_mask_file
    import mot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [MASK_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx_a,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output logic [MASK_W-1:0] rd_a,
    output logic [MASK_W-1:0] rd_b
);
    logic [MASK_W-1:0] kreg_q [NUM_MASKS];
    logic [MASK_W-1:0] kreg_d [NUM_MASKS];

    for (genvar g = 0; g < NUM_MASKS; g++) begin : g_kreg
        always_comb begin
            kreg_d[g] = kreg_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) kreg_d[g] = wr_data;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) kreg_q[g] <= '0;
            else        kreg_q[g] <= kreg_d[g];
        end
    end

    assign rd_a = kreg_q[rd_idx_a];
    assign rd_b = kreg_q[rd_idx_b];

    // R9: an unwritten register keeps its value across the edge
    a_r9_hold_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (kreg_q[0] == $past(kreg_q[0])) && (kreg_q[7] == $past(kreg_q[7])));
endmodule

// File: rtl/mot_flag_eval.sv
module mot_flag_eval
    import mot_pkg::*;
(
    input  logic [MASK_W-1:0] src_a,
    input  logic [MASK_W-1:0] src_b,
    input  wid_e              wid,
    output flags_t            flags
);
    localparam int LANES = 4;
    logic [MASK_W-1:0] lane_mask [LANES];
    logic [MASK_W-1:0] sel_mask;
    logic [MASK_W-1:0] merged;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int BITS = 8 << g;
        assign lane_mask[g] = {MASK_W{1'b1}} >> (MASK_W - BITS);
    end

    always_comb begin
        sel_mask = lane_mask[wid];
        merged   = (src_a | src_b) & sel_mask;
        flags    = '0;
        flags.zf = (merged == '0);
        flags.cf = (merged == sel_mask);
    end
endmodule

// File: rtl/mask_or_test_unit.sv
module mask_or_test_unit
    import mot_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        issue_vld,
    input  logic [7:0]  opc_byte,
    input  logic        vex_w,
    input  logic        vex_l,
    input  logic [1:0]  vex_pp,
    input  logic [7:0]  modrm,
    input  logic        mwr_en,
    input  logic [2:0]  mwr_idx,
    input  logic [63:0] mwr_data,
    output logic        zf_o,
    output logic        cf_o,
    output logic        of_o,
    output logic        sf_o,
    output logic        af_o,
    output logic        pf_o,
    output logic        ill_o
);
    typedef struct packed {
        flags_t flags;
        logic   ill;
    } state_t;

    state_t st_d, st_q;

    logic              legal;
    wid_e              wid;
    logic [IDX_W-1:0]  idx_a, idx_b;
    logic [MASK_W-1:0] src_a, src_b;
    flags_t            eval_flags;

    mot_decode u_dec (
        .opc_byte(opc_byte), .vex_w(vex_w), .vex_l(vex_l), .vex_pp(vex_pp),
        .modrm(modrm), .legal(legal), .wid(wid), .idx_a(idx_a), .idx_b(idx_b)
    );

    mot_mask_file u_kfile (
        .clk(clk), .rst_n(rst_n), .wr_en(mwr_en), .wr_idx(mwr_idx[IDX_W-1:0]),
        .wr_data(mwr_data[MASK_W-1:0]), .rd_idx_a(idx_a), .rd_idx_b(idx_b),
        .rd_a(src_a), .rd_b(src_b)
    );

    mot_flag_eval u_eval (
        .src_a(src_a), .src_b(src_b), .wid(wid), .flags(eval_flags)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ill = issue_vld && !legal;
        if (issue_vld && legal) st_d.flags = eval_flags;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign zf_o  = st_q.flags.zf;
    assign cf_o  = st_q.flags.cf;
    assign of_o  = st_q.flags.of;
    assign sf_o  = st_q.flags.sf;
    assign af_o  = st_q.flags.af;
    assign pf_o  = st_q.flags.pf;
    assign ill_o = st_q.ill;

    // R7: an invalid pulse always follows an issued instruction
    a_r7_ill_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ill_o |-> $past(issue_vld));
    // R7: flags keep their value across an invalid issue
    a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ill_o |-> $stable(st_q.flags));
    // R6: no issue, no flag change
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(issue_vld) |-> $stable(st_q.flags));
    // R2, R3: a result cannot be all zeros and all ones at once
    a_r3_zf_cf_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(zf_o && cf_o));
    // R5: the four cleared flags stay low
    a_r5_others_low: assert property (@(posedge clk) disable iff (!rst_n)
        !(of_o || sf_o || af_o || pf_o));
endmodule

// File: tb/mask_or_test_unit_bench.sv
module mask_or_test_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_vld = 1'b0;
    logic [7:0]  opc_byte = 8'h98;
    logic        vex_w = 1'b0;
    logic        vex_l = 1'b0;
    logic [1:0]  vex_pp = 2'b00;
    logic [7:0]  modrm = 8'hC0;
    logic        mwr_en = 1'b0;
    logic [2:0]  mwr_idx = 3'd0;
    logic [63:0] mwr_data = '0;
    logic zf_o, cf_o, of_o, sf_o, af_o, pf_o, ill_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mask_or_test_unit u_mask_or_test_unit (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .opc_byte(opc_byte),
        .vex_w(vex_w), .vex_l(vex_l), .vex_pp(vex_pp), .modrm(modrm),
        .mwr_en(mwr_en), .mwr_idx(mwr_idx), .mwr_data(mwr_data),
        .zf_o(zf_o), .cf_o(cf_o), .of_o(of_o), .sf_o(sf_o), .af_o(af_o),
        .pf_o(pf_o), .ill_o(ill_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // flags packed as {zf,cf,of,sf,af,pf}
    function automatic logic [5:0] fl();
        return {zf_o, cf_o, of_o, sf_o, af_o, pf_o};
    endfunction

    task automatic wr(input logic [2:0] idx, input logic [63:0] data);
        @(negedge clk);
        mwr_en = 1'b1; mwr_idx = idx; mwr_data = data;
        @(posedge clk);
        @(negedge clk);
        mwr_en = 1'b0;
    endtask

    // issue one instruction; sample at the negedge after the issuing edge
    task automatic issue(input logic [7:0] opc, input logic w, input logic l,
                         input logic [1:0] pp, input logic [7:0] mrm);
        @(negedge clk);
        issue_vld = 1'b1; opc_byte = opc; vex_w = w; vex_l = l; vex_pp = pp; modrm = mrm;
        @(posedge clk);
        @(negedge clk);
        issue_vld = 1'b0;
    endtask

    task automatic test(input logic w, input logic [1:0] pp, input logic [2:0] ra,
                        input logic [2:0] rb);
        issue(8'h98, w, 1'b0, pp, {2'b11, ra, rb});
    endtask

    task automatic t_reset();
        chk("R10 flags", 64'(fl()), 64'h0);
        chk("R10 ill", 64'(ill_o), 64'h0);
        test(1'b1, 2'b00, 3'd3, 3'd6);
        chk("R10 masks zero ZF/CF", 64'(fl()), 64'b100000);
        chk("R7 no ill on legal", 64'(ill_o), 64'h0);
    endtask

    task automatic t_widths();
        wr(3'd1, 64'h0000_0000_0000_00F0);
        wr(3'd2, 64'h0000_0000_0000_000F);
        test(1'b0, 2'b01, 3'd1, 3'd2);
        chk("R1 R3 W=0 66h is 8-bit, CF", 64'(fl()), 64'b010000);
        test(1'b0, 2'b00, 3'd1, 3'd2);
        chk("R1 R2 W=0 none is 16-bit", 64'(fl()), 64'b000000);
        wr(3'd3, 64'hFFFF_FFFF_0000_FF00);
        wr(3'd4, 64'h0000_0000_FFFF_00FF);
        test(1'b1, 2'b00, 3'd3, 3'd4);
        chk("R1 R3 64-bit all ones", 64'(fl()), 64'b010000);
        test(1'b1, 2'b01, 3'd3, 3'd4);
        chk("R1 R3 32-bit all ones", 64'(fl()), 64'b010000);
        wr(3'd5, 64'hFFFF_FFFF_FFFF_FF00);
        test(1'b1, 2'b00, 3'd5, 3'd0);
        chk("R3 64-bit low byte clear", 64'(fl()), 64'b000000);
    endtask

    task automatic t_upper();
        test(1'b0, 2'b01, 3'd5, 3'd0);
        chk("R4 8-bit ignores upper ones", 64'(fl()), 64'b100000);
        wr(3'd6, 64'hFFFF_FF00_0000_0000);
        test(1'b1, 2'b01, 3'd6, 3'd0);
        chk("R4 32-bit ignores upper", 64'(fl()), 64'b100000);
        test(1'b1, 2'b00, 3'd0, 3'd6);
        chk("R2 64-bit sees upper", 64'(fl()), 64'b000000);
        wr(3'd6, 64'h0001_0000_0000_FFFF);
        test(1'b0, 2'b00, 3'd6, 3'd6);
        chk("R4 R3 16-bit ones, bit 48 ignored", 64'(fl()), 64'b010000);
        test(1'b1, 2'b01, 3'd6, 3'd6);
        chk("R5 others clear 32-bit", 64'(fl()), 64'b000000);
    endtask

    task automatic t_invalid();
        test(1'b0, 2'b00, 3'd0, 3'd0);
        chk("R2 setup ZF", 64'(fl()), 64'b100000);
        issue(8'h98, 1'b0, 1'b0, 2'b00, 8'h80 | 8'h0A);
        chk("R7 mod!=11 ill", 64'(ill_o), 64'h1);
        chk("R7 mod!=11 flags kept", 64'(fl()), 64'b100000);
        @(negedge clk);
        chk("R7 pulse one cycle", 64'(ill_o), 64'h0);
        issue(8'h98, 1'b0, 1'b1, 2'b00, 8'hCA);
        chk("R7 L=1 ill", 64'(ill_o), 64'h1);
        chk("R7 L=1 flags kept", 64'(fl()), 64'b100000);
        issue(8'h98, 1'b0, 1'b0, 2'b10, 8'hCA);
        chk("R7 pp=10 ill", 64'(ill_o), 64'h1);
        issue(8'h98, 1'b1, 1'b0, 2'b11, 8'hCA);
        chk("R7 pp=11 ill", 64'(ill_o), 64'h1);
        issue(8'h99, 1'b0, 1'b0, 2'b00, 8'hCA);
        chk("R7 opcode ill", 64'(ill_o), 64'h1);
        chk("R7 flags after all invalid", 64'(fl()), 64'b100000);
        repeat (3) @(negedge clk);
        chk("R6 idle flags hold", 64'(fl()), 64'b100000);
        chk("R6 idle no ill", 64'(ill_o), 64'h0);
    endtask

    task automatic t_select();
        test(1'b0, 2'b01, 3'd1, 3'd0);
        chk("R8 reg field k1", 64'(fl()), 64'b000000);
        test(1'b0, 2'b01, 3'd0, 3'd2);
        chk("R8 rm field k2", 64'(fl()), 64'b000000);
        test(1'b0, 2'b01, 3'd0, 3'd0);
        chk("R8 k0 unchanged", 64'(fl()), 64'b100000);
        test(1'b0, 2'b01, 3'd1, 3'd2);
        chk("R8 k1,k2 unchanged", 64'(fl()), 64'b010000);
    endtask

    task automatic t_collide();
        @(negedge clk);
        issue_vld = 1'b1; opc_byte = 8'h98; vex_w = 1'b0; vex_l = 1'b0;
        vex_pp = 2'b00; modrm = {2'b11, 3'd7, 3'd7};
        mwr_en = 1'b1; mwr_idx = 3'd7; mwr_data = 64'h0000_0000_0000_FFFF;
        @(posedge clk);
        @(negedge clk);
        issue_vld = 1'b0; mwr_en = 1'b0;
        chk("R9 same-cycle test sees old", 64'(fl()), 64'b100000);
        test(1'b0, 2'b00, 3'd7, 3'd7);
        chk("R9 write landed", 64'(fl()), 64'b010000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_widths();
        t_upper();
        t_invalid();
        t_select();
        t_collide();
        done = 1;
    end

    initial begin : watchdog
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule